// File: doc/BRIEF.md
# I2C Control Register and Bus-Release Unit

This block holds the CPU-written control byte of an I2C peripheral and turns its command bits into bus behaviour. One bit turns the peripheral on. Two bits act as one-shot commands that clear themselves: one abandons the transfer in progress, the other ends a clock-stretch wait. The remaining bits (stop-interrupt select, wait-timing select, acknowledge enable, start request and stop request) are stored for neighbouring logic. The block also keeps the status flags it is responsible for. It drives active-low open-drain enables for the clock and data lines.

A bus monitor, which is outside this block, sends it single-cycle pulses for start, stop, own-address match and extension-code receipt, plus a pulse marking the ninth-clock wait. After an abandon command the unit parks in a standby state with both lines released. It leaves standby on a stop condition, or on an address match or extension code that arrives after a start condition.

Top module: `i2c_ctrl_release`

## Requirements
- R1: During and after reset the control byte and the status byte read 00h, and standby, wait and both line drive enables are 0.
- R2: A write stores control bits 7 (enable), 4, 3, 2, 1 (start request) and 0 (stop request). Bits 6 (abandon) and 5 (wait release) always read back as 0, on the cycle after the write and afterwards.
- R3: With enable already 1, a write with bits 7 and 6 set does four things in the next cycle: it clears control bits 1 and 0, clears status bits 5..0, raises standby and releases both lines.
- R4: In standby, a stop pulse clears standby in the next cycle.
- R5: In standby, an address-match or extension-code pulse clears standby only if a start pulse came earlier during that standby. With no earlier start, standby stays 1.
- R6: A ninth-clock pulse, while enabled and not in standby, sets wait and drives the clock line low. A write with bits 7 and 5 set ends the wait and releases the clock line.
- R7: A wait release while waiting with status bit 3 (transmit) at 1 clears bit 3 and releases the data line.
- R8: While enable is 0, writes to bits 6 and 5 have no effect: standby stays 0 and a ninth-clock pulse drives nothing.
- R9: Writing enable to 0 clears the status byte, standby and wait in the next cycle.
- R10: A write that turns enable from 0 to 1 while the clock input is 1 and the data input is 0 sets status bit 5 (start seen).
- R11: Status bits are set as follows: bit 0 by the master pulse, bit 1 by address match, bit 2 by extension code, bit 3 by the transmit pulse and bit 4 by the acknowledge pulse. A start pulse sets bit 5 and clears bit 6. A stop pulse sets bit 6 and clears bit 5. Bit 7 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle control write strobe |
| wr_data | input | 8 | Control write data |
| ctrl_rd | output | 8 | Control byte read value |
| scl_in | input | 1 | Sampled clock line level |
| sda_in | input | 1 | Sampled data line level |
| det_start | input | 1 | Start condition pulse |
| det_stop | input | 1 | Stop condition pulse |
| det_addr_match | input | 1 | Own address matched pulse |
| det_ext_code | input | 1 | Extension code received pulse |
| set_master | input | 1 | Master status set pulse |
| set_transmit | input | 1 | Transmit direction set pulse |
| set_ack_seen | input | 1 | Acknowledge detected pulse |
| ninth_wait | input | 1 | Ninth-clock wait entry pulse |
| sda_req | input | 1 | Data-line low request from the shifter |
| scl_drive_low | output | 1 | Clock line open-drain low enable |
| sda_drive_low | output | 1 | Data line open-drain low enable |
| standby | output | 1 | Standby after abandon |
| wait_active | output | 1 | Clock-stretch wait in progress |
| status | output | 8 | Status flag byte |

## Verification
A sequence of events drives every status flag up and down. This separates which pulse owns which bit, and shows that start and stop clear each other. Standby is left once by a stop and once by an extension code after a start, with an address match before the start tried first. That pair separates the two exit paths. Wait release is tried with the transmit flag set, where the data line must also let go. The commands are also written while disabled, to show they are ignored.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
    localparam int unsigned REG_W = 8;

    // control bit positions
    localparam int unsigned C_EN   = 7;
    localparam int unsigned C_EXIT = 6;
    localparam int unsigned C_WCAN = 5;
    localparam int unsigned C_STT  = 1;
    localparam int unsigned C_SPT  = 0;

    // status bit positions
    localparam int unsigned S_MST = 0;
    localparam int unsigned S_COI = 1;
    localparam int unsigned S_EXC = 2;
    localparam int unsigned S_TRC = 3;
    localparam int unsigned S_ACK = 4;
    localparam int unsigned S_STD = 5;
    localparam int unsigned S_SPD = 6;
    localparam int unsigned S_TOP = REG_W - 1;

    localparam logic [REG_W-1:0] EXIT_CLR_MASK = REG_W'(8'h3F);

    typedef struct packed {
        logic standby;
        logic start_seen;
        logic wait_on;
        logic sda_rel;
    } line_st_t;
endpackage

// File: rtl/i2cr_ctrl_reg.sv
module i2cr_ctrl_reg
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_q,
    output logic             en_next,
    output logic             exit_cmd,
    output logic             wcan_cmd,
    output logic             en_rise
);
    logic [REG_W-1:0] ctrl_d;

    always_comb begin
        // commands act only when the unit is on and stays on
        exit_cmd = wr_en & ctrl_q[C_EN] & wr_data[C_EN] & wr_data[C_EXIT];
        wcan_cmd = wr_en & ctrl_q[C_EN] & wr_data[C_EN] & wr_data[C_WCAN];
        en_rise  = wr_en & wr_data[C_EN] & ~ctrl_q[C_EN];
        ctrl_d   = ctrl_q;
        if (wr_en) begin
            ctrl_d         = wr_data;
            ctrl_d[C_EXIT] = 1'b0;
            ctrl_d[C_WCAN] = 1'b0;
        end
        if (exit_cmd) begin
            ctrl_d[C_STT] = 1'b0;
            ctrl_d[C_SPT] = 1'b0;
        end
        en_next = ctrl_d[C_EN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/i2cr_status.sv
module i2cr_status
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_next,
    input  logic             en_rise,
    input  logic             exit_cmd,
    input  logic             wcan_cmd,
    input  logic             wait_on,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             det_start,
    input  logic             det_stop,
    input  logic             det_match,
    input  logic             det_ext,
    input  logic             set_master,
    input  logic             set_transmit,
    input  logic             set_ack,
    output logic [REG_W-1:0] stat_q
);
    logic [REG_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (det_start) begin
            stat_d[S_STD] = 1'b1;
            stat_d[S_SPD] = 1'b0;
        end
        if (det_stop) begin
            stat_d[S_SPD] = 1'b1;
            stat_d[S_STD] = 1'b0;
        end
        if (en_rise && scl_in && !sda_in) stat_d[S_STD] = 1'b1;
        if (det_match)    stat_d[S_COI] = 1'b1;
        if (det_ext)      stat_d[S_EXC] = 1'b1;
        if (set_master)   stat_d[S_MST] = 1'b1;
        if (set_transmit) stat_d[S_TRC] = 1'b1;
        if (set_ack)      stat_d[S_ACK] = 1'b1;
        // release in transmit wait turns the direction to receive
        if (wcan_cmd && wait_on && stat_q[S_TRC]) stat_d[S_TRC] = 1'b0;
        if (exit_cmd) stat_d = stat_d & ~EXIT_CLR_MASK;
        stat_d[S_TOP] = 1'b0;
        if (!en_next) stat_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end
endmodule

// File: rtl/i2cr_line_ctrl.sv
module i2cr_line_ctrl
    import i2cr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic en_next,
    input  logic exit_cmd,
    input  logic wcan_cmd,
    input  logic trc_q,
    input  logic det_start,
    input  logic det_stop,
    input  logic det_match,
    input  logic det_ext,
    input  logic ninth_wait,
    input  logic sda_req,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic standby,
    output logic wait_active
);
    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.standby) begin
            if (det_start) st_d.start_seen = 1'b1;
            if (det_stop || (st_q.start_seen && (det_match || det_ext))) begin
                st_d.standby    = 1'b0;
                st_d.start_seen = 1'b0;
            end
        end
        if (det_start || det_stop || ninth_wait) st_d.sda_rel = 1'b0;
        if (wcan_cmd && st_q.wait_on) begin
            st_d.wait_on = 1'b0;
            if (trc_q) st_d.sda_rel = 1'b1;
        end
        if (ninth_wait && en_q && !st_q.standby) st_d.wait_on = 1'b1;
        if (exit_cmd) begin
            st_d.standby    = 1'b1;
            st_d.start_seen = 1'b0;
            st_d.wait_on    = 1'b0;
            st_d.sda_rel    = 1'b0;
        end
        if (!en_next) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scl_drive_low = st_q.wait_on & ~st_q.standby;
    assign sda_drive_low = en_q & sda_req & ~st_q.standby & ~st_q.sda_rel;
    assign standby       = st_q.standby;
    assign wait_active   = st_q.wait_on;
endmodule

// File: rtl/i2c_ctrl_release.sv
module i2c_ctrl_release
    import i2cr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] ctrl_rd,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             det_start,
    input  logic             det_stop,
    input  logic             det_addr_match,
    input  logic             det_ext_code,
    input  logic             set_master,
    input  logic             set_transmit,
    input  logic             set_ack_seen,
    input  logic             ninth_wait,
    input  logic             sda_req,
    output logic             scl_drive_low,
    output logic             sda_drive_low,
    output logic             standby,
    output logic             wait_active,
    output logic [REG_W-1:0] status
);
    logic en_next, exit_cmd, wcan_cmd, en_rise;

    i2cr_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctrl_q(ctrl_rd), .en_next(en_next), .exit_cmd(exit_cmd),
        .wcan_cmd(wcan_cmd), .en_rise(en_rise)
    );

    i2cr_status u_stat (
        .clk(clk), .rst_n(rst_n), .en_next(en_next), .en_rise(en_rise),
        .exit_cmd(exit_cmd), .wcan_cmd(wcan_cmd), .wait_on(wait_active),
        .scl_in(scl_in), .sda_in(sda_in), .det_start(det_start),
        .det_stop(det_stop), .det_match(det_addr_match), .det_ext(det_ext_code),
        .set_master(set_master), .set_transmit(set_transmit),
        .set_ack(set_ack_seen), .stat_q(status)
    );

    i2cr_line_ctrl u_line (
        .clk(clk), .rst_n(rst_n), .en_q(ctrl_rd[C_EN]), .en_next(en_next),
        .exit_cmd(exit_cmd), .wcan_cmd(wcan_cmd), .trc_q(status[S_TRC]),
        .det_start(det_start), .det_stop(det_stop), .det_match(det_addr_match),
        .det_ext(det_ext_code), .ninth_wait(ninth_wait), .sda_req(sda_req),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .standby(standby), .wait_active(wait_active)
    );
endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker
    import i2cr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] ctrl_rd,
    input logic             det_stop,
    input logic             ninth_wait,
    input logic             scl_drive_low,
    input logic             sda_drive_low,
    input logic             standby,
    input logic [REG_W-1:0] status
);
    a_r2_selfclear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd[C_EXIT] == 1'b0 && ctrl_rd[C_WCAN] == 1'b0);

    a_r3_exit_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctrl_rd[C_EN] && wr_data[C_EN] && wr_data[C_EXIT])
        |=> (standby && status[5:0] == 6'd0 && !scl_drive_low && !sda_drive_low
             && ctrl_rd[C_STT] == 1'b0 && ctrl_rd[C_SPT] == 1'b0));

    a_r4_stop_leaves_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && det_stop && !wr_en) |=> !standby);

    a_r6_ninth_holds_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (ninth_wait && ctrl_rd[C_EN] && !standby && !wr_en) |=> scl_drive_low);

    a_r8_disabled_no_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctrl_rd[C_EN] && wr_data[C_EXIT]) |=> !standby);

    a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[C_EN]) |=> (status == '0 && !standby && !scl_drive_low));
endmodule

bind i2c_ctrl_release i2cr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_rd(ctrl_rd), .det_stop(det_stop), .ninth_wait(ninth_wait),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
    .standby(standby), .status(status)
);

// File: tb/i2c_ctrl_release_bench.sv
module i2c_ctrl_release_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;
    // {wr, data, events(start,stop,match,ext,mst,trc,ack,ninth), exp_ctrl, exp_stat, exp_standby}
    localparam logic [33:0] VEC [NVEC] = '{
        {1'b1, 8'h80, 8'h00, 8'h80, 8'h00, 1'b0},
        {1'b1, 8'h9F, 8'h00, 8'h9F, 8'h00, 1'b0},
        {1'b0, 8'h00, 8'h80, 8'h9F, 8'h20, 1'b0},
        {1'b0, 8'h00, 8'h28, 8'h9F, 8'h23, 1'b0},
        {1'b0, 8'h00, 8'h16, 8'h9F, 8'h3F, 1'b0},
        {1'b0, 8'h00, 8'h40, 8'h9F, 8'h5F, 1'b0},
        {1'b1, 8'hC3, 8'h00, 8'h80, 8'h40, 1'b1},
        {1'b0, 8'h00, 8'h20, 8'h80, 8'h42, 1'b1},
        {1'b0, 8'h00, 8'h80, 8'h80, 8'h22, 1'b1},
        {1'b0, 8'h00, 8'h10, 8'h80, 8'h26, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic det_start = 0, det_stop = 0, det_addr_match = 0, det_ext_code = 0;
    logic set_master = 0, set_transmit = 0, set_ack_seen = 0, ninth_wait = 0, sda_req = 0;
    logic [7:0] ctrl_rd, status;
    logic scl_drive_low, sda_drive_low, standby, wait_active;
    int n_chk = 0, n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_ctrl_release u_i2c_ctrl_release (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic [7:0] ev);
        wr_en = w; wr_data = d;
        {det_start, det_stop, det_addr_match, det_ext_code,
         set_master, set_transmit, set_ack_seen, ninth_wait} = ev;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        {det_start, det_stop, det_addr_match, det_ext_code,
         set_master, set_transmit, set_ack_seen, ninth_wait} = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 ctrl in reset", ctrl_rd, 8'h00);
        chk("R1 status in reset", status, 8'h00);
        chk("R1 lines in reset", {standby, wait_active, scl_drive_low, sda_drive_low}, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {ctrl_rd, status}, 16'h0000);

        // table: R2 storage, R11 flag owners, R3 exit, R5 standby exits
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][33], VEC[i][32:25], VEC[i][24:17]);
            chk($sformatf("R2/R11 vec%0d ctrl", i), ctrl_rd, VEC[i][16:9]);
            chk($sformatf("R11/R3 vec%0d status", i), status, VEC[i][8:1]);
            chk($sformatf("R3/R5 vec%0d standby", i), standby, VEC[i][0]);
        end

        // R3: abandon releases both lines; R4: stop leaves standby
        sda_req = 1'b1;
        step(1'b0, 8'h00, 8'h01);
        chk("R6 wait drives clock", scl_drive_low, 1'b1);
        chk("R3 data driven before exit", sda_drive_low, 1'b1);
        step(1'b1, 8'hC0, 8'h00);
        chk("R3 standby after exit", standby, 1'b1);
        chk("R3 lines released", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R3 status cleared", status, 8'h00);
        step(1'b0, 8'h00, 8'h40);
        chk("R4 stop ends standby", standby, 1'b0);
        chk("R4 status after stop", status, 8'h40);
        sda_req = 1'b0;

        // R6/R7: wait release in transmit
        step(1'b0, 8'h00, 8'h04);
        chk("R11 transmit flag", status, 8'h48);
        sda_req = 1'b1;
        step(1'b0, 8'h00, 8'h01);
        chk("R6 wait active", {wait_active, scl_drive_low, sda_drive_low}, 3'b111);
        step(1'b1, 8'hA0, 8'h00);
        chk("R6 wait ended", {wait_active, scl_drive_low}, 2'b00);
        chk("R6 release bit reads 0", ctrl_rd, 8'h80);
        chk("R7 direction cleared", status, 8'h40);
        chk("R7 data released", sda_drive_low, 1'b0);
        sda_req = 1'b0;

        // R9: disable clears state
        step(1'b0, 8'h00, 8'h80);
        step(1'b0, 8'h00, 8'h01);
        chk("R9 pre-disable wait", scl_drive_low, 1'b1);
        step(1'b1, 8'h00, 8'h00);
        chk("R9 status cleared", status, 8'h00);
        chk("R9 wait and standby cleared", {wait_active, standby, scl_drive_low}, 3'b000);

        // R8: commands ignored while disabled
        step(1'b1, 8'h40, 8'h00);
        chk("R8 exit ignored", standby, 1'b0);
        chk("R8 ctrl unchanged", ctrl_rd, 8'h00);
        step(1'b1, 8'h20, 8'h01);
        chk("R8 wait not entered", {wait_active, scl_drive_low}, 2'b00);

        // R10: enable during clock high, data low
        sda_in = 1'b0;
        step(1'b1, 8'h80, 8'h00);
        chk("R10 start on enable", status, 8'h20);
        sda_in = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule